// File: doc/BRIEF.md
# ALU Status Flags Register

This block holds the status flags of a 16-bit arithmetic unit in one 8-bit register. Two of the flags mirror the active accumulator at all times: one is set when the accumulator is zero, the other copies its sign bit. Three flags are latched when the arithmetic unit reports an operation: overflow, carry/borrow and equals. Two general-purpose bits are left entirely to software. The carry, equals and general-purpose bits can be written through a plain register write port. The zero, sign and overflow bits are read-only.

The arithmetic unit presents each operation as a single-cycle `op_valid` pulse. The pulse carries the operation code, both operands, and the adder's carries out of the two top bit positions. There is no back-pressure: the block accepts an operation in every cycle, so no ready signal exists. A latched flag changes at the clock edge that samples the operation and is readable right after that edge. The read port is combinational, built from the stored bits and the live accumulator value.

Top module: `alu_flag_reg`

## Requirements
- R1: While `rst_n` is low, every stored flag clears to 0. After reset with the accumulator at zero, `flags_rd` reads 8'h80.
- R2: `flags_rd[7]` is 1 in the same cycle whenever `acc_value` is zero, and 0 otherwise. No clock edge is needed.
- R3: `flags_rd[6]` equals the top bit of `acc_value` in the same cycle.
- R4: An operation with `op_code` 0 (add), 1 (add with carry), 2 (subtract) or 3 (subtract with borrow) sets `flags_rd[2]` to the XOR of `cy_pre_msb` and `cy_msb` after the sampling edge.
- R5: The overflow bit keeps its value through compare operations, through codes 5 to 7 (no flag effect), and through software writes.
- R6: An operation with code 0 or 1 sets `flags_rd[1]` to `cy_msb`.
- R7: An operation with code 2 or 3 sets `flags_rd[1]` to the inverse of `cy_msb`, which is the borrow.
- R8: Code 4 (compare) sets `flags_rd[0]` to 1 when `opnd_a` equals `opnd_b` and to 0 otherwise. A compare changes no other flag.
- R9: A software write stores `sw_wr_data[4:3]` in the general-purpose bits, `sw_wr_data[1]` in the carry bit and `sw_wr_data[0]` in the equals bit.
- R10: Software writes to bits 7, 6, 5 and 2 have no effect. Bit 5 always reads 0.
- R11: When a software write and an operation that updates the carry or equals bit fall in the same cycle, the operation's value is stored in that bit. The software value is still stored in the other writable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_value | input | 16 | Current active accumulator |
| op_valid | input | 1 | Operation report pulse |
| op_code | input | 3 | Operation code (0 add, 1 add-carry, 2 sub, 3 sub-borrow, 4 compare) |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| cy_pre_msb | input | 1 | Adder carry out of bit 14 |
| cy_msb | input | 1 | Adder carry out of bit 15 |
| sw_wr_en | input | 1 | Software register write strobe |
| sw_wr_data | input | 8 | Software write data |
| flags_rd | output | 8 | Flag register read value |

## Verification
A corrupted latched flag stays visible on `flags_rd` from the edge after the bad update until the next operation or software write that touches that bit. Overflow is the exception: it lasts until the next arithmetic operation, because software cannot repair it. A fault in the live zero or sign path shows up at once, in the same cycle the accumulator changes, with no register in between. The priority and read-only rules are checked by reading the register in the cycle right after a write that collides with an operation, or right after a write aimed at a protected bit.

// File: rtl/flag_pkg.sv
package flag_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUB  = 3'd2,
    OP_SUBB = 3'd3,
    OP_CMP  = 3'd4
  } op_e;

  localparam int BIT_ZERO = 7;
  localparam int BIT_SIGN = 6;
  localparam int BIT_RSVD = 5;
  localparam int BIT_GPHI = 4;
  localparam int BIT_GPLO = 3;
  localparam int BIT_OVF  = 2;
  localparam int BIT_CY   = 1;
  localparam int BIT_EQ   = 0;
  localparam int REG_W    = 8;

  typedef struct packed {
    logic upd;
    logic val;
  } flag_upd_t;
endpackage

// File: rtl/flag_event_unit.sv
module flag_event_unit
  import flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              cy_pre_msb,
  input  logic              cy_msb,
  output flag_upd_t         ovf_upd,
  output flag_upd_t         cy_upd,
  output flag_upd_t         eq_upd
);
  logic is_add, is_sub, is_cmp;

  always_comb begin
    is_add = 1'b0;
    is_sub = 1'b0;
    is_cmp = 1'b0;
    if (op_valid) begin
      unique case (op_code)
        OP_ADD, OP_ADDC: is_add = 1'b1;
        OP_SUB, OP_SUBB: is_sub = 1'b1;
        OP_CMP:          is_cmp = 1'b1;
        default: ;
      endcase
    end
  end

  // signed overflow: carry into the sign bit disagrees with carry out of it
  assign ovf_upd.upd = is_add | is_sub;
  assign ovf_upd.val = cy_pre_msb ^ cy_msb;

  // subtraction reports borrow, the complement of the two's-complement carry
  assign cy_upd.upd  = is_add | is_sub;
  assign cy_upd.val  = is_sub ? ~cy_msb : cy_msb;

  assign eq_upd.upd  = is_cmp;
  assign eq_upd.val  = (opnd_a == opnd_b);
endmodule

// File: rtl/flag_sw_port.sv
module flag_sw_port
  import flag_pkg::*;
(
  input  logic             sw_wr_en,
  input  logic [REG_W-1:0] sw_wr_data,
  output logic             gp_we,
  output logic [1:0]       gp_d,
  output flag_upd_t        cy_sw,
  output flag_upd_t        eq_sw
);
  localparam logic [REG_W-1:0] WR_MASK =
    (REG_W'(1) << BIT_GPHI) | (REG_W'(1) << BIT_GPLO) |
    (REG_W'(1) << BIT_CY)   | (REG_W'(1) << BIT_EQ);

  logic [REG_W-1:0] masked;
  assign masked     = sw_wr_data & WR_MASK;
  assign gp_we      = sw_wr_en;
  assign gp_d       = masked[BIT_GPHI:BIT_GPLO];
  assign cy_sw.upd  = sw_wr_en;
  assign cy_sw.val  = masked[BIT_CY];
  assign eq_sw.upd  = sw_wr_en;
  assign eq_sw.val  = masked[BIT_EQ];
endmodule

// File: rtl/flag_live_mirror.sv
module flag_live_mirror #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] acc_value,
  output logic              zero_f,
  output logic              sign_f
);
  assign zero_f = ~|acc_value;
  assign sign_f = acc_value[DATA_W-1];
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] acc_value,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              cy_pre_msb,
  input  logic              cy_msb,
  input  logic              sw_wr_en,
  input  logic [REG_W-1:0]  sw_wr_data,
  output logic [REG_W-1:0]  flags_rd
);
  flag_upd_t  ovf_hw, cy_hw, eq_hw, cy_sw, eq_sw;
  logic       gp_we;
  logic [1:0] gp_d;
  logic       zero_f, sign_f;

  logic       ovf_q, cy_q, eq_q;
  logic [1:0] gp_q;

  flag_event_unit #(.DATA_W(DATA_W)) u_evt (
    .op_valid   (op_valid),
    .op_code    (op_code),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .cy_pre_msb (cy_pre_msb),
    .cy_msb     (cy_msb),
    .ovf_upd    (ovf_hw),
    .cy_upd     (cy_hw),
    .eq_upd     (eq_hw)
  );

  flag_sw_port u_sw (
    .sw_wr_en   (sw_wr_en),
    .sw_wr_data (sw_wr_data),
    .gp_we      (gp_we),
    .gp_d       (gp_d),
    .cy_sw      (cy_sw),
    .eq_sw      (eq_sw)
  );

  flag_live_mirror #(.DATA_W(DATA_W)) u_live (
    .acc_value (acc_value),
    .zero_f    (zero_f),
    .sign_f    (sign_f)
  );

  // hardware update outranks software on shared bits
  function automatic logic pick(input flag_upd_t hw, input flag_upd_t sw,
                                input logic cur);
    if (hw.upd)      return hw.val;
    else if (sw.upd) return sw.val;
    else             return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      cy_q  <= 1'b0;
      eq_q  <= 1'b0;
      gp_q  <= '0;
    end else begin
      if (ovf_hw.upd) ovf_q <= ovf_hw.val;
      cy_q <= pick(cy_hw, cy_sw, cy_q);
      eq_q <= pick(eq_hw, eq_sw, eq_q);
      if (gp_we) gp_q <= gp_d;
    end
  end

  always_comb begin
    flags_rd                      = '0;
    flags_rd[BIT_ZERO]            = zero_f;
    flags_rd[BIT_SIGN]            = sign_f;
    flags_rd[BIT_RSVD]            = 1'b0;
    flags_rd[BIT_GPHI:BIT_GPLO]   = gp_q;
    flags_rd[BIT_OVF]             = ovf_q;
    flags_rd[BIT_CY]              = cy_q;
    flags_rd[BIT_EQ]              = eq_q;
  end
endmodule

// File: rtl/alu_flag_reg_chk.sv
module alu_flag_reg_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] acc_value,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic              cy_pre_msb,
  input logic              cy_msb,
  input logic              sw_wr_en,
  input logic [7:0]        sw_wr_data,
  input logic [7:0]        flags_rd
);
  logic arith, addop, subop, cmpop;
  assign addop = op_valid && (op_code == 3'd0 || op_code == 3'd1);
  assign subop = op_valid && (op_code == 3'd2 || op_code == 3'd3);
  assign cmpop = op_valid && (op_code == 3'd4);
  assign arith = addop || subop;

  AST_ZERO_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    flags_rd[7] |-> (acc_value == '0));                               // R2
  AST_SIGN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    flags_rd[6] == acc_value[DATA_W-1]);                              // R3
  AST_OVF_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
    arith |=> flags_rd[2] == ($past(cy_pre_msb) ^ $past(cy_msb)));    // R4
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !arith |=> $stable(flags_rd[2]));                                  // R5
  AST_CY_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    addop |=> flags_rd[1] == $past(cy_msb));                           // R6
  AST_CY_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    subop |=> flags_rd[1] == !$past(cy_msb));                          // R7
  AST_EQ_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    cmpop |=> flags_rd[0] == ($past(opnd_a) == $past(opnd_b)));        // R8
  AST_GP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> flags_rd[4:3] == $past(sw_wr_data[4:3]));             // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    flags_rd[5] == 1'b0);                                              // R10
endmodule

bind alu_flag_reg alu_flag_reg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_value(acc_value), .op_valid(op_valid),
  .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .cy_pre_msb(cy_pre_msb), .cy_msb(cy_msb), .sw_wr_en(sw_wr_en),
  .sw_wr_data(sw_wr_data), .flags_rd(flags_rd)
);

// File: tb/test_alu_flag_reg.sv
`timescale 1ns/1ps
module test_alu_flag_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] acc_value;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [15:0] opnd_a, opnd_b;
  logic        cy_pre_msb, cy_msb;
  logic        sw_wr_en;
  logic [7:0]  sw_wr_data;
  logic [7:0]  flags_rd;

  int n_cmp = 0;
  int n_bad = 0;

  // expected stored state
  logic e_ov, e_c, e_e;
  logic [1:0] e_gp;

  always #2 clk = ~clk;

  alu_flag_reg i_alu_flag_reg (
    .clk(clk), .rst_n(rst_n), .acc_value(acc_value), .op_valid(op_valid),
    .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .cy_pre_msb(cy_pre_msb), .cy_msb(cy_msb), .sw_wr_en(sw_wr_en),
    .sw_wr_data(sw_wr_data), .flags_rd(flags_rd)
  );

  function automatic logic [7:0] expect_rd();
    return {(acc_value == 16'h0), acc_value[15], 1'b0, e_gp, e_ov, e_c, e_e};
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    n_cmp++;
    if (flags_rd !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, flags_rd, exp);
    end
  endtask

  task automatic idle_inputs();
    op_valid = 1'b0; op_code = 3'd7; opnd_a = '0; opnd_b = '0;
    cy_pre_msb = 1'b0; cy_msb = 1'b0; sw_wr_en = 1'b0; sw_wr_data = '0;
  endtask

  // drive one cycle of stimulus, then release and sample after the edge
  task automatic cycle_op(input logic v, input logic [2:0] code,
                          input logic [15:0] a, input logic [15:0] b,
                          input logic c14, input logic c15,
                          input logic w, input logic [7:0] wd);
    @(negedge clk);
    op_valid = v; op_code = code; opnd_a = a; opnd_b = b;
    cy_pre_msb = c14; cy_msb = c15; sw_wr_en = w; sw_wr_data = wd;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic t_reset();
    idle_inputs();
    acc_value = 16'h0000;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    e_ov = 0; e_c = 0; e_e = 0; e_gp = 0;
    @(negedge clk);
    check("R1 reset value", 8'h80);
  endtask

  task automatic t_live();
    acc_value = 16'h0001; #1; check("R2 nonzero acc", expect_rd());
    acc_value = 16'h8000; #1; check("R3 sign set", expect_rd());
    acc_value = 16'h0000; #1; check("R2 zero acc", expect_rd());
    acc_value = 16'h7FFF; #1; check("R3 sign clear", expect_rd());
  endtask

  task automatic t_add();
    cycle_op(1, 3'd0, 16'h7FFF, 16'h0001, 1, 0, 0, 8'h00);
    e_ov = 1; e_c = 0; check("R4 R6 add overflow", expect_rd());
    cycle_op(1, 3'd1, 16'hFFFF, 16'h0001, 1, 1, 0, 8'h00);
    e_ov = 0; e_c = 1; check("R6 addc carry", expect_rd());
    cycle_op(1, 3'd0, 16'h8000, 16'h8000, 0, 1, 0, 8'h00);
    e_ov = 1; e_c = 1; check("R4 add neg overflow", expect_rd());
  endtask

  task automatic t_sub();
    cycle_op(1, 3'd2, 16'h0001, 16'h0002, 0, 0, 0, 8'h00);
    e_ov = 0; e_c = 1; check("R7 sub borrow", expect_rd());
    cycle_op(1, 3'd3, 16'h0005, 16'h0002, 1, 1, 0, 8'h00);
    e_ov = 0; e_c = 0; check("R7 subb no borrow", expect_rd());
    cycle_op(1, 3'd2, 16'h8000, 16'h0001, 0, 1, 0, 8'h00);
    e_ov = 1; e_c = 0; check("R4 sub overflow", expect_rd());
  endtask

  task automatic t_cmp();
    cycle_op(1, 3'd4, 16'h1234, 16'h1234, 0, 0, 0, 8'h00);
    e_e = 1; check("R8 cmp equal, R5 ov kept", expect_rd());
    cycle_op(1, 3'd4, 16'h1234, 16'h1235, 1, 0, 0, 8'h00);
    e_e = 0; check("R8 cmp differ", expect_rd());
  endtask

  task automatic t_other();
    cycle_op(1, 3'd6, 16'h0000, 16'h0000, 0, 0, 0, 8'h00);
    check("R5 no-effect code keeps flags", expect_rd());
  endtask

  task automatic t_sw_write();
    cycle_op(0, 3'd7, 0, 0, 0, 0, 1, 8'h1B);
    e_gp = 2'b11; e_c = 1; e_e = 1; check("R9 write gp c e", expect_rd());
    cycle_op(0, 3'd7, 0, 0, 0, 0, 1, 8'h08);
    e_gp = 2'b01; e_c = 0; e_e = 0; check("R9 write partial", expect_rd());
  endtask

  task automatic t_ro();
    cycle_op(0, 3'd7, 0, 0, 0, 0, 1, 8'hE4);
    e_gp = 2'b00; e_c = 0; e_e = 0;
    check("R10 R5 read-only bits ignored", expect_rd());
    cycle_op(1, 3'd0, 16'h1, 16'h1, 0, 0, 0, 8'h00);
    e_ov = 0; e_c = 0;
    cycle_op(0, 3'd7, 0, 0, 0, 0, 1, 8'h04);
    check("R5 ov not writable", expect_rd());
  endtask

  task automatic t_priority();
    cycle_op(1, 3'd0, 16'hFFFF, 16'h0001, 1, 1, 1, 8'h11);
    e_c = 1; e_ov = 0; e_gp = 2'b10; e_e = 1;
    check("R11 hw carry beats sw", expect_rd());
    cycle_op(1, 3'd4, 16'h0001, 16'h0002, 0, 0, 1, 8'h0D);
    e_e = 0; e_c = 0; e_gp = 2'b01;
    check("R11 hw equals beats sw", expect_rd());
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_live();
    t_add();
    t_sub();
    t_cmp();
    t_other();
    t_sw_write();
    t_ro();
    t_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule